// File: doc/BRIEF.md
# Inter-Core Doorbell Interrupt Unit

This unit lets any of several bus masters ring a doorbell interrupt toward any of `N_CORES` target cores. Each target has a trigger register and a pending-source register. A write to a trigger register can fire a one-cycle interrupt pulse toward its target. The same write raises sticky per-source flags that record which senders rang. The target core reads its pending-source register to find every sender that signalled, including senders that rang while it was still servicing an earlier interrupt. It then clears the flags it handled by writing ones to them.

All trigger registers sit behind one write guard. The guard opens only after a two-step key sequence on two key registers. The guard is shared and has no owner: once any master opens it, trigger writes from every master take effect. No master ever waits on another. Several write ports, one per master, can write in the same cycle. There is one registered read port.

Address map (word addresses, defaults): trigger register of core k at k, pending-source register of core k at `N_CORES`+k, key register A at 2·`N_CORES`, key register B at 2·`N_CORES`+1.

Top module: `ipc_doorbell`

## Requirements
- R1: After reset the guard is closed, every pending-source flag is 0, `irq` is all zeros and `rd_data` is 0.
- R2: While the guard is closed, writes to trigger registers are ignored: no interrupt pulse and no flag change.
- R3: The guard opens only when key register A receives `KEY_A` (default 32'h5A3C_0F01) and a later write puts `KEY_B` (default 32'hC3A5_7E02) into key register B. Writing `KEY_B` without a prior `KEY_A` leaves it closed. When several ports write key registers in the same cycle, they take effect in port index order.
- R4: Any other value written to either key register closes the guard, whether it was armed or open.
- R5: The guard has no owner: after one port opens it, trigger writes from any other port take effect immediately.
- R6: An accepted trigger write with bit 0 (fire bit) set gives a one-cycle high pulse on `irq[k]` in the cycle after the write. With bit 0 clear, no pulse is given, but the source bits are still recorded. Several accepted fire writes to the same target in one cycle give one pulse.
- R7: Trigger-write bits [`N_SRC`+3:4] set the matching pending-source flags of that target. Flags are sticky and accumulate across writes and across ports, including writes from two ports in the same cycle.
- R8: A read with `rd_en` high returns, on `rd_data` in the next cycle, the flags of the addressed target in bits [`N_SRC`-1:0], with all other bits 0. A read of any other address returns 0. `rd_data` holds its value while `rd_en` is low.
- R9: Writing a pending-source register clears each flag whose data bit [`N_SRC`-1:0] is 1 and leaves flags under 0 bits unchanged. This works whether the guard is open or closed.
- R10: If a trigger write sets a flag in the same cycle that a pending-source write clears it, the flag ends set.
- R11: A trigger or pending-source write to target k changes no flag and no `irq` bit of any other target.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | N_PORTS | Per-port write strobe |
| wr_addr | input | N_PORTS×ADDR_W | Per-port word address |
| wr_data | input | N_PORTS×DATA_W | Per-port write data |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | ADDR_W | Read word address |
| rd_data | output | DATA_W | Registered read data |
| irq | output | N_CORES | Per-target interrupt pulse |

## Verification
The bench opens the guard with a half sequence, with the keys swapped, and with a bad value after arming. A design that kept partial progress, or that ignored wrong keys, would fire interrupts while it should be closed. One port opens the guard and the other port rings. Both ports ring one target in the same cycle, and a ring and a clear land on one flag together. An owner-tied guard, a last-writer-wins flag update or a clear-priority merge would each lose a sender's flag or give a double pulse. Fire-bit-clear writes, write-0 clears, clears while closed and reads of untouched targets catch designs that pulse without the fire bit, clear without a one, or leak writes into neighbouring targets.

// File: rtl/ipcd_pkg.sv
package ipcd_pkg;

  typedef enum logic [1:0] {
    LK_SHUT  = 2'd0,
    LK_ARMED = 2'd1,
    LK_OPEN  = 2'd2
  } lock_state_e;

  // bit positions inside a trigger-register write
  localparam int FIRE_BIT = 0;
  localparam int SRC_LSB  = 4;

endpackage

// File: rtl/ipcd_port_dec.sv
module ipcd_port_dec #(
  parameter int N_CORES = 8,
  parameter int ADDR_W  = 5
) (
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  addr,
  output logic [N_CORES-1:0] gen_sel,
  output logic [N_CORES-1:0] ack_sel,
  output logic               keya_sel,
  output logic               keyb_sel
);
  localparam int ACK_BASE = N_CORES;
  localparam int KEYA_ADR = 2 * N_CORES;
  localparam int KEYB_ADR = 2 * N_CORES + 1;

  for (genvar k = 0; k < N_CORES; k++) begin : g_core
    assign gen_sel[k] = wr_en && (addr == ADDR_W'(k));
    assign ack_sel[k] = wr_en && (addr == ADDR_W'(ACK_BASE + k));
  end

  assign keya_sel = wr_en && (addr == ADDR_W'(KEYA_ADR));
  assign keyb_sel = wr_en && (addr == ADDR_W'(KEYB_ADR));
endmodule

// File: rtl/ipcd_lock.sv
module ipcd_lock
  import ipcd_pkg::*;
#(
  parameter int           N_PORTS = 2,
  parameter int           DATA_W  = 32,
  parameter logic [31:0]  KEY_A   = 32'h5A3C_0F01,
  parameter logic [31:0]  KEY_B   = 32'hC3A5_7E02
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [N_PORTS-1:0]             keya_sel,
  input  logic [N_PORTS-1:0]             keyb_sel,
  input  logic [N_PORTS-1:0][DATA_W-1:0] wdata,
  output logic                           open,
  output logic                           armed
);
  lock_state_e st_q, st_d;
  logic        st_en;

  // ports apply in index order within a cycle
  always_comb begin
    st_d = st_q;
    for (int p = 0; p < N_PORTS; p++) begin
      if (keya_sel[p]) begin
        if (wdata[p] == DATA_W'(KEY_A)) begin
          st_d = (st_d == LK_OPEN) ? LK_OPEN : LK_ARMED;
        end else begin
          st_d = LK_SHUT;
        end
      end
      if (keyb_sel[p]) begin
        if (wdata[p] == DATA_W'(KEY_B)) begin
          st_d = (st_d == LK_SHUT) ? LK_SHUT : LK_OPEN;
        end else begin
          st_d = LK_SHUT;
        end
      end
    end
  end

  assign st_en = (|keya_sel) | (|keyb_sel);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= LK_SHUT;
    end else if (st_en) begin
      st_q <= st_d;
    end
  end

  assign open  = (st_q == LK_OPEN);
  assign armed = (st_q == LK_ARMED);
endmodule

// File: rtl/ipcd_target.sv
module ipcd_target #(
  parameter int N_PORTS = 2,
  parameter int N_SRC   = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          open,
  input  logic [N_PORTS-1:0]            gen_sel,
  input  logic [N_PORTS-1:0]            ack_sel,
  input  logic [N_PORTS-1:0]            fire_bit,
  input  logic [N_PORTS-1:0][N_SRC-1:0] src_bits,
  input  logic [N_PORTS-1:0][N_SRC-1:0] clr_bits,
  output logic [N_SRC-1:0]              flags,
  output logic                          irq
);
  logic [N_SRC-1:0] flags_q, flags_d, set_v, clr_v;
  logic             flags_en;
  logic             fire_d, irq_q;

  always_comb begin
    set_v  = '0;
    clr_v  = '0;
    fire_d = 1'b0;
    for (int p = 0; p < N_PORTS; p++) begin
      if (gen_sel[p] && open) begin
        set_v  = set_v | src_bits[p];
        fire_d = fire_d | fire_bit[p];
      end
      if (ack_sel[p]) begin
        clr_v = clr_v | clr_bits[p];
      end
    end
    // set has priority over a clear of the same flag
    flags_d  = (flags_q & ~clr_v) | set_v;
    flags_en = (|set_v) | (|clr_v);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
    end else if (flags_en) begin
      flags_q <= flags_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q <= 1'b0;
    end else begin
      irq_q <= fire_d;
    end
  end

  assign flags = flags_q;
  assign irq   = irq_q;
endmodule

// File: rtl/ipc_doorbell.sv
module ipc_doorbell
  import ipcd_pkg::*;
#(
  parameter int          N_CORES = 8,
  parameter int          N_SRC   = 8,
  parameter int          N_PORTS = 2,
  parameter int          DATA_W  = 32,
  parameter int          ADDR_W  = 5,
  parameter logic [31:0] KEY_A   = 32'h5A3C_0F01,
  parameter logic [31:0] KEY_B   = 32'hC3A5_7E02
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [N_PORTS-1:0]             wr_en,
  input  logic [N_PORTS-1:0][ADDR_W-1:0] wr_addr,
  input  logic [N_PORTS-1:0][DATA_W-1:0] wr_data,
  input  logic                           rd_en,
  input  logic [ADDR_W-1:0]              rd_addr,
  output logic [DATA_W-1:0]              rd_data,
  output logic [N_CORES-1:0]             irq
);
  localparam int ACK_BASE = N_CORES;

  // reset: asynchronous assert, synchronous release
  logic rst_meta_q, rst_q_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_q_n    <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_q_n    <= rst_meta_q;
    end
  end

  // per-port decode
  logic [N_PORTS-1:0][N_CORES-1:0] gen_pp, ack_pp;
  logic [N_PORTS-1:0]              keya_sel, keyb_sel;
  logic [N_PORTS-1:0]              fire_bit;
  logic [N_PORTS-1:0][N_SRC-1:0]   src_bits, clr_bits;

  for (genvar p = 0; p < N_PORTS; p++) begin : g_port
    ipcd_port_dec #(.N_CORES(N_CORES), .ADDR_W(ADDR_W)) u_dec (
      .wr_en    (wr_en[p]),
      .addr     (wr_addr[p]),
      .gen_sel  (gen_pp[p]),
      .ack_sel  (ack_pp[p]),
      .keya_sel (keya_sel[p]),
      .keyb_sel (keyb_sel[p])
    );
    assign fire_bit[p] = wr_data[p][FIRE_BIT];
    assign src_bits[p] = wr_data[p][SRC_LSB +: N_SRC];
    assign clr_bits[p] = wr_data[p][N_SRC-1:0];
  end

  logic lock_open, lock_armed;
  ipcd_lock #(
    .N_PORTS (N_PORTS),
    .DATA_W  (DATA_W),
    .KEY_A   (KEY_A),
    .KEY_B   (KEY_B)
  ) u_lock (
    .clk      (clk),
    .rst_n    (rst_q_n),
    .keya_sel (keya_sel),
    .keyb_sel (keyb_sel),
    .wdata    (wr_data),
    .open     (lock_open),
    .armed    (lock_armed)
  );

  logic [N_CORES-1:0][N_SRC-1:0] flags;
  logic [N_CORES*N_SRC-1:0]      flags_flat;

  for (genvar k = 0; k < N_CORES; k++) begin : g_tgt
    logic [N_PORTS-1:0] gen_k, ack_k;
    for (genvar p = 0; p < N_PORTS; p++) begin : g_tp
      assign gen_k[p] = gen_pp[p][k];
      assign ack_k[p] = ack_pp[p][k];
    end
    ipcd_target #(.N_PORTS(N_PORTS), .N_SRC(N_SRC)) u_tgt (
      .clk      (clk),
      .rst_n    (rst_q_n),
      .open     (lock_open),
      .gen_sel  (gen_k),
      .ack_sel  (ack_k),
      .fire_bit (fire_bit),
      .src_bits (src_bits),
      .clr_bits (clr_bits),
      .flags    (flags[k]),
      .irq      (irq[k])
    );
    assign flags_flat[k*N_SRC +: N_SRC] = flags[k];
  end

  // registered read port
  logic [DATA_W-1:0] rd_d, rd_q;
  always_comb begin
    rd_d = '0;
    for (int k = 0; k < N_CORES; k++) begin
      if (rd_addr == ADDR_W'(ACK_BASE + k)) begin
        rd_d[N_SRC-1:0] = flags[k];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      rd_q <= '0;
    end else if (rd_en) begin
      rd_q <= rd_d;
    end
  end

  assign rd_data = rd_q;
endmodule

// File: rtl/ipc_doorbell_chk.sv
module ipc_doorbell_chk #(
  parameter int N_CORES = 8,
  parameter int N_SRC   = 8,
  parameter int N_PORTS = 2
) (
  input logic                     clk,
  input logic                     rst_q_n,
  input logic [N_PORTS-1:0]       wr_en,
  input logic [N_CORES-1:0]       irq,
  input logic                     lock_open,
  input logic                     lock_armed,
  input logic [N_CORES*N_SRC-1:0] flags_flat
);
  AST_IRQ_NEEDS_OPEN: assert property (@(posedge clk) disable iff (!rst_q_n)
    (|irq) |-> ($past(lock_open) && $past(|wr_en))); // R2

  AST_OPEN_AFTER_ARM: assert property (@(posedge clk) disable iff (!rst_q_n)
    $rose(lock_open) |-> ($past(lock_armed) || ($past($countones(wr_en)) > 1))); // R3

  AST_LOCK_MOVES_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_q_n)
    (lock_open != $past(lock_open)) |-> $past(|wr_en)); // R4

  AST_FLAG_SET_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_q_n)
    ((flags_flat & ~$past(flags_flat)) != '0) |-> ($past(lock_open) && $past(|wr_en))); // R7

  AST_FLAG_CLR_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_q_n)
    ((~flags_flat & $past(flags_flat)) != '0) |-> $past(|wr_en)); // R9
endmodule

bind ipc_doorbell ipc_doorbell_chk #(
  .N_CORES (N_CORES),
  .N_SRC   (N_SRC),
  .N_PORTS (N_PORTS)
) u_chk (
  .clk        (clk),
  .rst_q_n    (rst_q_n),
  .wr_en      (wr_en),
  .irq        (irq),
  .lock_open  (lock_open),
  .lock_armed (lock_armed),
  .flags_flat (flags_flat)
);

// File: tb/ipc_doorbell_tb.sv
module ipc_doorbell_tb;
  localparam int CLK_PER = 10;
  localparam logic [31:0] KA = 32'h5A3C_0F01;
  localparam logic [31:0] KB = 32'hC3A5_7E02;
  localparam logic [4:0]  KEYA = 5'd16;
  localparam logic [4:0]  KEYB = 5'd17;

  logic             clk = 1'b0;
  logic             rst_n;
  logic [1:0]       wr_en;
  logic [1:0][4:0]  wr_addr;
  logic [1:0][31:0] wr_data;
  logic             rd_en;
  logic [4:0]       rd_addr;
  logic [31:0]      rd_data;
  logic [7:0]       irq;

  always #(CLK_PER/2) clk = ~clk;

  ipc_doorbell u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_data(rd_data), .irq(irq)
  );

  typedef struct {
    string       tag;
    logic [7:0]  irq;
    bit          chk_rd;
    logic [31:0] rd;
  } exp_t;

  exp_t q[$];
  exp_t it;
  int   total = 0;
  int   bad   = 0;
  string cur = "R1";

  // reference state built from the requirements
  logic [7:0] m_flags [8];
  int         m_lock;   // 0 shut, 1 armed, 2 open

  // monitor: one scoreboard item per clock after reset
  always @(posedge clk) begin
    #(CLK_PER/4);
    if (q.size() > 0) begin
      it = q.pop_front();
      total++;
      if (irq !== it.irq) begin
        bad++;
        $display("FAIL %s irq actual=%h expected=%h", it.tag, irq, it.irq);
      end
      if (it.chk_rd) begin
        total++;
        if (rd_data !== it.rd) begin
          bad++;
          $display("FAIL %s rd_data actual=%h expected=%h", it.tag, rd_data, it.rd);
        end
      end
    end
  end

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  // driver: model the cycle, push the expected item, advance
  task automatic step();
    exp_t       e;
    logic [7:0] setv [8];
    logic [7:0] clrv [8];
    bit         open;
    e.tag = cur; e.irq = '0; e.chk_rd = rd_en; e.rd = '0;
    for (int k = 0; k < 8; k++) begin setv[k] = '0; clrv[k] = '0; end
    if (rd_en && rd_addr >= 5'd8 && rd_addr < 5'd16)
      e.rd = {24'h0, m_flags[rd_addr - 5'd8]};
    open = (m_lock == 2);
    for (int p = 0; p < 2; p++) begin
      if (wr_en[p]) begin
        if (wr_addr[p] < 5'd8 && open) begin
          if (wr_data[p][0]) e.irq[wr_addr[p]] = 1'b1;
          setv[wr_addr[p]] |= wr_data[p][11:4];
        end else if (wr_addr[p] >= 5'd8 && wr_addr[p] < 5'd16) begin
          clrv[wr_addr[p] - 5'd8] |= wr_data[p][7:0];
        end
      end
    end
    for (int k = 0; k < 8; k++) m_flags[k] = (m_flags[k] & ~clrv[k]) | setv[k];
    for (int p = 0; p < 2; p++) begin
      if (wr_en[p] && wr_addr[p] == KEYA)
        m_lock = (wr_data[p] == KA) ? ((m_lock == 2) ? 2 : 1) : 0;
      if (wr_en[p] && wr_addr[p] == KEYB)
        m_lock = (wr_data[p] == KB) ? ((m_lock == 0) ? 0 : 2) : 0;
    end
    q.push_back(e);
    @(negedge clk);
    wr_en = '0; rd_en = 1'b0;
  endtask

  task automatic wr(int p, logic [4:0] a, logic [31:0] d);
    wr_en[p] = 1'b1; wr_addr[p] = a; wr_data[p] = d;
    step();
  endtask

  task automatic rd(logic [4:0] a);
    rd_en = 1'b1; rd_addr = a;
    step();
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic unlock(int p);
    wr(p, KEYA, KA);
    wr(p, KEYB, KB);
  endtask

  initial begin
    #(CLK_PER*20000);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; wr_en = '0; wr_addr = '0; wr_data = '0; rd_en = 1'b0; rd_addr = '0;
    m_lock = 0;
    for (int k = 0; k < 8; k++) m_flags[k] = '0;
    repeat (3) @(negedge clk);
    chk("R1 irq in reset", {24'h0, irq}, 32'h0);
    chk("R1 rd_data in reset", rd_data, 32'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 irq after reset", {24'h0, irq}, 32'h0);

    cur = "R1";
    for (int k = 0; k < 8; k++) rd(5'(8 + k));

    cur = "R2";  // trigger writes ignored while shut
    wr(0, 5'd3, 32'h0000_0FF1);
    wr(1, 5'd0, 32'h0000_0011);
    rd(5'd11); rd(5'd8);

    cur = "R3";  // key B alone, swapped keys
    wr(0, KEYB, KB);
    wr(0, 5'd3, 32'h0000_0011);
    wr(0, KEYB, KB); wr(0, KEYA, KA);
    rd(5'd11);
    wr(0, KEYB, KB);  // completes sequence (A then B)
    wr(0, 5'd3, 32'h0000_0011);
    idle(1); rd(5'd11);

    cur = "R6";  // fire bit clear: flags only
    wr(1, 5'd2, 32'h0000_0400);
    rd(5'd10);

    cur = "R5";  // port 0 opened, port 1 rings
    wr(1, 5'd7, 32'h0000_0021);
    cur = "R7";
    wr(0, 5'd7, 32'h0000_0011);
    rd(5'd15);
    // both ports ring core 5 in one cycle
    wr_en = 2'b11; wr_addr[0] = 5'd5; wr_addr[1] = 5'd5;
    wr_data[0] = 32'h0000_0101; wr_data[1] = 32'h0000_0201;
    step();
    rd(5'd13);
    // back-to-back rings: two pulses
    wr(0, 5'd4, 32'h0000_0011); wr(1, 5'd4, 32'h0000_0021);
    rd(5'd12);

    cur = "R8";
    rd(5'd3); rd(5'd20); idle(2);

    cur = "R9";  // write-one-to-clear, zero bits unchanged
    wr(0, 5'd15, 32'h0000_0001);
    rd(5'd15);
    wr(1, 5'd15, 32'h0000_0000);
    rd(5'd15);

    cur = "R10"; // set and clear of one flag in one cycle
    wr_en = 2'b11; wr_addr[0] = 5'd7; wr_addr[1] = 5'd15;
    wr_data[0] = 32'h0000_0041; wr_data[1] = 32'h0000_0006;
    step();
    rd(5'd15);

    cur = "R11"; // neighbours untouched
    rd(5'd14); rd(5'd8); rd(5'd9);

    cur = "R4";  // bad key value closes an open guard
    wr(0, KEYA, 32'h0000_0000);
    wr(1, 5'd6, 32'h0000_0011);
    rd(5'd14);
    unlock(1);
    wr(0, 5'd6, 32'h0000_0011);
    wr(1, KEYB, 32'h1234_5678);
    wr(0, 5'd6, 32'h0000_0021);
    rd(5'd14);
    // armed then wrong key B, then right key B: stays shut
    wr(0, KEYA, KA); wr(0, KEYB, 32'h0);
    wr(0, KEYB, KB);
    wr(0, 5'd1, 32'h0000_0011);
    rd(5'd9);

    cur = "R9";  // clear works while shut
    wr(1, 5'd14, 32'h0000_00FF);
    rd(5'd14);
    wr(0, 5'd10, 32'h0000_0040);
    rd(5'd10);

    idle(3);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule